// File: doc/BRIEF.md
# Processor Execution State Sequencer

This block keeps track of the operating state of a small processor core and derives the control signals that follow from it. The core is always in one of five states. Normal processing runs instructions. Stopped is a quiet form of normal in which no bus cycles are issued. Exception processing covers the entry into a handler. Background is a debug mode. Halted is the state left after a fatal fault. Instruction decode, the datapath, vector fetch and stacking are modelled only as single-cycle event pulses on the inputs. The block turns those pulses into state changes.

The sequencer also holds the privilege bit. When the bit is 1 the core runs at supervisor level, and when it is 0 the core runs at user level. The bit picks which of the two stack pointers is active. It also forms the top bit of the function code that goes out with every bus access. The lower function-code bits are the address-space bits supplied by the core. All state is registered, so an event applied in one cycle shows on the outputs after the next rising clock edge.

Top module: `cpu_state_seq`

## Requirements
- R1: `state_o` uses these codes: 0 normal, 1 stopped, 2 exception, 3 background, 4 halted. While `rst_n` is low at a clock edge, the block goes to exception (2) with the privilege bit at supervisor (1).
- R2: In normal state, a trace, interrupt, bus error or address error moves the core to exception state. The privilege bit is set to 1 on that entry.
- R3: In normal state with no exception event and no background request, a stop pulse moves the core to stopped. `bus_en` is low while stopped.
- R4: In stopped state, only trace, interrupt or a reset event leave, and all three go to exception. Stop, background request, resume, bus error, address error, handler start and status writes have no effect there.
- R5: In exception state with no fault, a handler-start pulse returns the core to normal.
- R6: A bus error or address error in exception state moves the core to halted, even when handler start is also present. While halted, `halted` is 1 and `bus_en` is 0.
- R7: Halted is left only by a reset event. Trace, interrupt and all other events keep the core halted.
- R8: A reset event (`ev_reset`) wins over every other input in every state. It moves the core to exception and sets the privilege bit to 1.
- R9: A background request enters background (3) only from normal state, and only when no exception event is present. It has lower priority than the exception events and higher priority than stop. In background, `bus_en` is 0 and only a resume pulse or a reset event leave. Resume returns the core to normal.
- R10: A status write (`sr_wr`) loads `sr_s_in` into the privilege bit only in normal state, and only when no exception entry happens in the same cycle. `sp_sel` equals the privilege bit. `fc` is the privilege bit placed above `fc_space`. `bus_en` is 1 in normal and exception states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_stop | input | 1 | Stop instruction executed |
| ev_trace | input | 1 | Trace exception pending |
| ev_irq | input | 1 | Interrupt exception pending |
| ev_reset | input | 1 | Reset exception event |
| ev_bg_req | input | 1 | Request to enter background debug |
| ev_bg_resume | input | 1 | Leave background debug |
| ev_bus_err | input | 1 | Bus error detected |
| ev_addr_err | input | 1 | Address error detected |
| ev_hstart | input | 1 | First instruction of handler starts |
| sr_wr | input | 1 | Status privilege bit write strobe |
| sr_s_in | input | 1 | Value written to the privilege bit |
| fc_space | input | SPACE_W | Address-space part of the function code |
| state_o | output | 3 | Current state code |
| bus_en | output | 1 | Bus cycles allowed |
| halted | output | 1 | Core halted |
| sp_sel | output | 1 | Active stack pointer, 1 = supervisor |
| fc | output | SPACE_W+1 | Function code, privilege bit on top |

## Verification
The assertions assume that every event input is a known 0 or 1 at each rising edge. They also treat any mix of events in one cycle as legal, with the priority order resolving the mix. They do not assume pulses are exclusive, and they do not assume handler start arrives only during exception processing. The stimulus therefore drives each event independently from a seeded random source with per-event weights, so collisions such as a fault together with handler start, or a stop together with an interrupt, happen often. Directed sequences then step through the stopped, halted and background paths, including a status write attempted while stopped.

// File: rtl/cpu_state_pkg.sv
// Shared types for the execution state sequencer.
// Assumes: state codes are decoded outside the block by value.
package cpu_state_pkg;

    // Operating states; codes are visible on state_o.
    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_STOPPED = 3'd1,
        ST_EXCEPT  = 3'd2,
        ST_BGND    = 3'd3,
        ST_HALTED  = 3'd4
    } cpu_state_e;

    // Decoded single-cycle events from the rest of the core.
    typedef struct packed {
        logic stop;
        logic trace;
        logic irq;
        logic rst_exc;
        logic bg_req;
        logic bg_resume;
        logic bus_err;
        logic addr_err;
        logic h_start;
    } cpu_evt_t;

endpackage

// File: rtl/cpu_state_fsm.sv
// Holds the operating state and computes its transitions.
// Assumes: events are one-cycle pulses sampled on the rising edge;
// a reset event has top priority in every state.
module cpu_state_fsm
    import cpu_state_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cpu_evt_t   evt,
    output cpu_state_e state,
    output logic       enter_exc
);

    cpu_state_e state_nxt;
    logic       exc_req;
    logic       fault;

    assign exc_req = evt.trace | evt.irq;
    assign fault   = evt.bus_err | evt.addr_err;

    // Next-state selection with the priority order per state.
    always_comb begin
        state_nxt = state;
        enter_exc = 1'b0;
        if (evt.rst_exc) begin
            state_nxt = ST_EXCEPT;
            enter_exc = 1'b1;
        end else begin
            case (state)
                ST_NORMAL: begin
                    if (exc_req || fault) begin
                        state_nxt = ST_EXCEPT;
                        enter_exc = 1'b1;
                    end else if (evt.bg_req) begin
                        state_nxt = ST_BGND;
                    end else if (evt.stop) begin
                        state_nxt = ST_STOPPED;
                    end
                end
                ST_STOPPED: begin
                    if (exc_req) begin
                        state_nxt = ST_EXCEPT;
                        enter_exc = 1'b1;
                    end
                end
                ST_EXCEPT: begin
                    if (fault) begin
                        state_nxt = ST_HALTED;
                    end else if (evt.h_start) begin
                        state_nxt = ST_NORMAL;
                    end
                end
                ST_BGND: begin
                    if (evt.bg_resume) begin
                        state_nxt = ST_NORMAL;
                    end
                end
                ST_HALTED: state_nxt = ST_HALTED;
                default:   state_nxt = ST_HALTED;
            endcase
        end
    end

    // State register; reset begins exception processing for the reset vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EXCEPT;
        end else begin
            state <= state_nxt;
        end
    end

endmodule

// File: rtl/cpu_priv_ctrl.sv
// Holds the supervisor/user privilege bit.
// Assumes: enter_exc and wr_allow come from the state FSM in the same cycle.
module cpu_priv_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_exc,
    input  logic wr_allow,
    input  logic sr_wr,
    input  logic sr_s_in,
    output logic priv_s
);

    // Privilege register: forced to supervisor on reset and exception entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_s <= 1'b1;
        end else if (enter_exc) begin
            priv_s <= 1'b1;
        end else if (wr_allow && sr_wr) begin
            priv_s <= sr_s_in;
        end
    end

endmodule

// File: rtl/cpu_bus_ctrl.sv
// Derives bus enable, halted flag, stack select and function code.
// Assumes: inputs are registered, so the outputs change only after a clock edge.
module cpu_bus_ctrl
    import cpu_state_pkg::*;
#(
    parameter int SPACE_W = 2
) (
    input  cpu_state_e         state,
    input  logic               priv_s,
    input  logic [SPACE_W-1:0] fc_space,
    output logic               bus_en,
    output logic               halted,
    output logic               sp_sel,
    output logic [SPACE_W:0]   fc
);

    // Bus activity allowed only while running or entering a handler.
    always_comb begin
        case (state)
            ST_NORMAL, ST_EXCEPT: bus_en = 1'b1;
            default:              bus_en = 1'b0;
        endcase
    end

    assign halted = (state == ST_HALTED);
    assign sp_sel = priv_s;
    assign fc     = {priv_s, fc_space};

endmodule

// File: rtl/cpu_state_seq.sv
// Top of the execution state sequencer: bundles events and links the units.
// Assumes: all event inputs are synchronous single-cycle pulses.
module cpu_state_seq
    import cpu_state_pkg::*;
#(
    parameter int SPACE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_stop,
    input  logic               ev_trace,
    input  logic               ev_irq,
    input  logic               ev_reset,
    input  logic               ev_bg_req,
    input  logic               ev_bg_resume,
    input  logic               ev_bus_err,
    input  logic               ev_addr_err,
    input  logic               ev_hstart,
    input  logic               sr_wr,
    input  logic               sr_s_in,
    input  logic [SPACE_W-1:0] fc_space,
    output logic [2:0]         state_o,
    output logic               bus_en,
    output logic               halted,
    output logic               sp_sel,
    output logic [SPACE_W:0]   fc
);

    cpu_evt_t   evt;
    cpu_state_e state;
    logic       enter_exc;
    logic       priv_s;

    assign evt = '{stop: ev_stop, trace: ev_trace, irq: ev_irq,
                   rst_exc: ev_reset, bg_req: ev_bg_req,
                   bg_resume: ev_bg_resume, bus_err: ev_bus_err,
                   addr_err: ev_addr_err, h_start: ev_hstart};

    cpu_state_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .state     (state),
        .enter_exc (enter_exc)
    );

    cpu_priv_ctrl u_priv (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_exc (enter_exc),
        .wr_allow  (state == ST_NORMAL),
        .sr_wr     (sr_wr),
        .sr_s_in   (sr_s_in),
        .priv_s    (priv_s)
    );

    cpu_bus_ctrl #(.SPACE_W(SPACE_W)) u_bus (
        .state    (state),
        .priv_s   (priv_s),
        .fc_space (fc_space),
        .bus_en   (bus_en),
        .halted   (halted),
        .sp_sel   (sp_sel),
        .fc       (fc)
    );

    assign state_o = state;

endmodule

// File: rtl/cpu_state_seq_chk.sv
// Assertion checker for the execution state sequencer, bound to the top.
// Assumes: observes only top-level ports.
module cpu_state_seq_chk #(
    parameter int SPACE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ev_stop,
    input logic               ev_trace,
    input logic               ev_irq,
    input logic               ev_reset,
    input logic               ev_bg_req,
    input logic               ev_bg_resume,
    input logic               ev_bus_err,
    input logic               ev_addr_err,
    input logic               ev_hstart,
    input logic               sr_wr,
    input logic               sr_s_in,
    input logic [SPACE_W-1:0] fc_space,
    input logic [2:0]         state_o,
    input logic               bus_en,
    input logic               halted,
    input logic               sp_sel,
    input logic [SPACE_W:0]   fc
);

    logic any_exc;
    assign any_exc = ev_trace | ev_irq | ev_bus_err | ev_addr_err | ev_reset;

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) state_o <= 3'd4); // R1
    AST_NORMAL_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && (ev_irq || ev_trace)) |=> (state_o == 3'd2 && sp_sel)); // R2
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && ev_stop && !any_exc && !ev_bg_req) |=> (state_o == 3'd1 && !bus_en)); // R3
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && !ev_trace && !ev_irq && !ev_reset) |=> state_o == 3'd1); // R4
    AST_HSTART_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && ev_hstart && !ev_bus_err && !ev_addr_err && !ev_reset) |=> state_o == 3'd0); // R5
    AST_DFAULT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && (ev_bus_err || ev_addr_err) && !ev_reset) |=> (halted && !bus_en)); // R6
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !ev_reset) |=> halted); // R7
    AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_reset |=> (state_o == 3'd2 && sp_sel)); // R8
    AST_BG_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && ev_bg_resume && !ev_reset) |=> state_o == 3'd0); // R9
    AST_PRIV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && sr_wr && !any_exc) |=> sp_sel == $past(sr_s_in)); // R10
    AST_FC_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        fc == {sp_sel, fc_space}); // R10

endmodule

bind cpu_state_seq cpu_state_seq_chk #(.SPACE_W(SPACE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .ev_trace(ev_trace),
    .ev_irq(ev_irq), .ev_reset(ev_reset), .ev_bg_req(ev_bg_req),
    .ev_bg_resume(ev_bg_resume), .ev_bus_err(ev_bus_err),
    .ev_addr_err(ev_addr_err), .ev_hstart(ev_hstart), .sr_wr(sr_wr),
    .sr_s_in(sr_s_in), .fc_space(fc_space), .state_o(state_o),
    .bus_en(bus_en), .halted(halted), .sp_sel(sp_sel), .fc(fc)
);

// File: tb/sim_cpu_state_seq.sv
module sim_cpu_state_seq;
    localparam int SPACE_W = 2;
    localparam bit [8:0] E_STOP = 9'h100, E_TRACE = 9'h080, E_IRQ = 9'h040,
                         E_RST = 9'h020, E_BG = 9'h010, E_RES = 9'h008,
                         E_BERR = 9'h004, E_AERR = 9'h002, E_HS = 9'h001;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic ev_stop = 0, ev_trace = 0, ev_irq = 0, ev_reset = 0, ev_bg_req = 0;
    logic ev_bg_resume = 0, ev_bus_err = 0, ev_addr_err = 0, ev_hstart = 0;
    logic sr_wr = 0, sr_s_in = 0;
    logic [SPACE_W-1:0] fc_space = '0;
    logic [2:0] state_o;
    logic bus_en, halted, sp_sel;
    logic [SPACE_W:0] fc;

    int n_tests = 0, n_fail = 0;
    int exp_st = 2;
    bit exp_pr = 1'b1;
    string exp_tag = "R1";
    bit done = 1'b0;

    cpu_state_seq #(.SPACE_W(SPACE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .ev_trace(ev_trace),
        .ev_irq(ev_irq), .ev_reset(ev_reset), .ev_bg_req(ev_bg_req),
        .ev_bg_resume(ev_bg_resume), .ev_bus_err(ev_bus_err),
        .ev_addr_err(ev_addr_err), .ev_hstart(ev_hstart), .sr_wr(sr_wr),
        .sr_s_in(sr_s_in), .fc_space(fc_space), .state_o(state_o),
        .bus_en(bus_en), .halted(halted), .sp_sel(sp_sel), .fc(fc)
    );

    // Reference model of one clock edge, taken from the requirements.
    task automatic model_update();
        bit exc_ev = ev_trace | ev_irq;
        bit err = ev_bus_err | ev_addr_err;
        if (!rst_n) begin
            exp_st = 2; exp_pr = 1'b1; exp_tag = "R1";
        end else if (ev_reset) begin
            exp_st = 2; exp_pr = 1'b1; exp_tag = "R8";
        end else begin
            case (exp_st)
                0: begin
                    if (exc_ev || err) begin
                        exp_st = 2; exp_pr = 1'b1; exp_tag = "R2";
                    end else begin
                        if (sr_wr) exp_pr = sr_s_in;
                        exp_tag = "R10";
                        if (ev_bg_req) begin exp_st = 3; exp_tag = "R9"; end
                        else if (ev_stop) begin exp_st = 1; exp_tag = "R3"; end
                    end
                end
                1: begin
                    exp_tag = "R4";
                    if (exc_ev) begin exp_st = 2; exp_pr = 1'b1; end
                end
                2: begin
                    if (err) begin exp_st = 4; exp_tag = "R6"; end
                    else begin exp_tag = "R5"; if (ev_hstart) exp_st = 0; end
                end
                3: begin
                    exp_tag = "R9";
                    if (ev_bg_resume) exp_st = 0;
                end
                default: exp_tag = "R7";
            endcase
        end
    endtask

    // Compare all outputs with the model.
    task automatic check_outputs();
        bit [SPACE_W+5:0] got, exp;
        got = {state_o, bus_en, halted, sp_sel, fc};
        exp = {exp_st[2:0], (exp_st == 0 || exp_st == 2), (exp_st == 4), exp_pr, exp_pr, fc_space};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got st=%0d bus=%0b hlt=%0b sp=%0b fc=%0h, expected st=%0d bus=%0b hlt=%0b sp=%0b fc=%0h",
                     exp_tag, state_o, bus_en, halted, sp_sel, fc,
                     exp_st, (exp_st == 0 || exp_st == 2), (exp_st == 4), exp_pr, {exp_pr, fc_space});
        end
    endtask

    // Apply one cycle of stimulus at the falling edge and check the result.
    task automatic tick(input bit [8:0] ev, input bit wr, input bit s);
        {ev_stop, ev_trace, ev_irq, ev_reset, ev_bg_req, ev_bg_resume,
         ev_bus_err, ev_addr_err, ev_hstart} = ev;
        sr_wr = wr; sr_s_in = s;
        fc_space = SPACE_W'($urandom);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_outputs();
    endtask

    function automatic bit pick(input int w);
        return ($urandom % w) == 0;
    endfunction

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        tick(9'h0, 0, 0);                          // R1 reset state
        tick(E_IRQ | E_STOP, 1, 0);                // R1 events ignored in reset
        rst_n = 1'b1;
        tick(E_HS, 0, 0);                          // R5 to normal
        tick(9'h0, 1, 0);                          // R10 drop to user
        tick(E_STOP, 0, 0);                        // R3 stop
        tick(E_BG | E_HS | E_BERR | E_RES | E_STOP, 0, 0); // R4 ignored
        tick(9'h0, 1, 1);                          // R4 write ignored while stopped
        tick(E_IRQ, 0, 0);                         // R4 wake to exception
        tick(E_HS | E_BERR, 0, 0);                 // R6 double fault wins
        tick(E_IRQ | E_TRACE | E_HS, 0, 0);        // R7 stays halted
        tick(E_RST | E_BERR, 0, 0);                // R8 reset leaves halted
        tick(E_HS, 0, 0);                          // R5
        tick(E_BG | E_STOP, 0, 0);                 // R9 bg over stop
        tick(E_IRQ | E_STOP, 0, 0);                // R9 ignored in background
        tick(E_RES, 0, 0);                         // R9 resume
        tick(E_TRACE | E_BG, 1, 0);                // R2 trace over bg and write
        tick(E_AERR, 0, 0);                        // R6 address error halts
        tick(E_RST, 0, 0);                         // R8
        for (int i = 0; i < 6000; i++) begin
            bit [8:0] ev;
            ev = {pick(6), pick(10), pick(10), pick(60), pick(8), pick(4),
                  pick(14), pick(14), pick(3)};
            if (pick(700)) rst_n = 1'b0;
            else rst_n = 1'b1;
            tick(ev, pick(3), pick(2));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule